// File: doc/BRIEF.md
# Shared Forward/Inverse AES Byte Substitution Unit

This unit substitutes every byte of a 32-bit word with either its AES SubBytes value or its InvSubBytes value. A mode input picks the direction for each transfer. The unit holds a single 256-entry table, and that table holds multiplicative inverses in GF(2^8) under the field polynomial x^8+x^4+x^3+x+1, with 0x00 mapping to 0x00.

In the forward direction, each byte is first looked up in the inverse table and the result then goes through the affine map. In the inverse direction, each byte first goes through the inverse affine map and the result is then looked up in the same table. Both affine maps are plain XOR networks. The four byte lanes work in parallel, and each lane has its own pair of XOR networks. The table contents are computed when the design is elaborated and are read through one read port per lane.

A transfer is accepted whenever `in_valid_i` is high. The result is registered, so it appears one clock later with `out_valid_o` high. A round datapath can use the unit for the substitution step of encryption and also of decryption, with no second table.

Top module: `aes_dual_sbox`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0.
- R2: `out_valid_o` is high in the cycle after a clock edge at which `in_valid_i` was high, and low after an edge at which it was low.
- R3: With `mode_i`=0, each output byte equals the table inverse followed by the forward affine map. Output bit i is a_i^a_(i+4)^a_(i+5)^a_(i+6)^a_(i+7)^c_i, with indices taken mod 8 and c=0x63. This equals the standard S-box for all 256 inputs.
- R4: With `mode_i`=1, each output byte equals the inverse affine map followed by the table inverse. The inverse affine bit i is a_(i+2)^a_(i+5)^a_(i+7)^d_i, with d=0x05. This equals the standard inverse S-box for all 256 inputs.
- R5: Byte lane k is `data_i[8k+7:8k]` and maps only to `data_o[8k+7:8k]`, independently of the other lanes.
- R6: The table holds b with a·b=1 in GF(2^8) mod 0x11B for every nonzero a, and holds 0x00 for a=0x00.
- R7: After an edge at which `in_valid_i` was low, `data_o` keeps its previous value.
- R8: The unit gives forward(0x00)=0x63, forward(0x53)=0xED, inverse(0x63)=0x00 and inverse(0xED)=0x53.
- R9: `mode_i` is sampled with each transfer, so back-to-back transfers may alternate direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input word is valid this cycle |
| mode_i | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| data_i | input | 32 | Four input byte lanes |
| out_valid_o | output | 1 | Result valid |
| data_o | output | 32 | Four substituted byte lanes |

## Verification
On every cycle, the assertions check three things: the valid timing, that `data_o` holds while idle, and that the table entry read on each lane is a true field inverse of its address. The forward vector for a zero word is also asserted. Only the bench shows that the composed paths match the standard S-box and inverse S-box for every byte in every lane. It does this against an inverse found by brute-force search. The bench also shows that direction switches cleanly between back-to-back transfers.

// File: rtl/aes_sub_pkg.sv
package aes_sub_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned TBL_N   = 1 << BYTE_W;
  localparam logic [7:0]  POLY_LO = 8'h1B;
  localparam logic [7:0]  FWD_C   = 8'h63;
  localparam logic [7:0]  INV_C   = 8'h05;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t r;
    byte_t x;
    r = '0;
    x = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ((x << 1) ^ POLY_LO) : (x << 1);
    end
    return r;
  endfunction

  // a^254 == a^-1; gives 0 for 0
  function automatic byte_t gf_inv(byte_t a);
    byte_t p;
    byte_t r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [TBL_N*BYTE_W-1:0] build_inv_tbl();
    logic [TBL_N*BYTE_W-1:0] t;
    t = '0;
    for (int a = 0; a < TBL_N; a++) t[a*BYTE_W +: BYTE_W] = gf_inv(byte_t'(a));
    return t;
  endfunction

endpackage

// File: rtl/sub_inv_table.sv
module sub_inv_table
  import aes_sub_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  byte_t rd_addr_i [NUM_PORTS],
  output byte_t rd_data_o [NUM_PORTS]
);

  localparam logic [TBL_N*BYTE_W-1:0] INV_TBL = build_inv_tbl();

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign rd_data_o[p] = INV_TBL[{rd_addr_i[p], 3'b000} +: BYTE_W];

    always_comb begin
      if (rd_addr_i[p] == 8'h00) begin
        AST_ZERO_MAPS_ZERO: assert (rd_data_o[p] == 8'h00); // R6
      end else begin
        AST_TRUE_INVERSE: assert (gf_mul(rd_addr_i[p], rd_data_o[p]) == 8'h01); // R6
      end
    end
  end

endmodule

// File: rtl/sub_affine_fwd.sv
module sub_affine_fwd
  import aes_sub_pkg::*;
(
  input  byte_t a_i,
  output byte_t y_o
);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign y_o[i] = a_i[i] ^ a_i[(i+4)%8] ^ a_i[(i+5)%8] ^ a_i[(i+6)%8]
                  ^ a_i[(i+7)%8] ^ FWD_C[i];
  end

endmodule

// File: rtl/sub_affine_inv.sv
module sub_affine_inv
  import aes_sub_pkg::*;
(
  input  byte_t a_i,
  output byte_t y_o
);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign y_o[i] = a_i[(i+2)%8] ^ a_i[(i+5)%8] ^ a_i[(i+7)%8] ^ INV_C[i];
  end

endmodule

// File: rtl/aes_dual_sbox.sv
module aes_dual_sbox
  import aes_sub_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] data_o
);

  localparam int unsigned LANES = WORD_W / BYTE_W;

  byte_t tbl_addr [LANES];
  byte_t tbl_data [LANES];
  logic [WORD_W-1:0] sub_word;

  sub_inv_table #(.NUM_PORTS(LANES)) u_tbl (
    .rd_addr_i (tbl_addr),
    .rd_data_o (tbl_data)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    byte_t in_b;
    byte_t pre_inv;
    byte_t post_fwd;

    assign in_b = data_i[k*BYTE_W +: BYTE_W];

    sub_affine_inv u_ainv (.a_i(in_b),        .y_o(pre_inv));
    sub_affine_fwd u_afwd (.a_i(tbl_data[k]), .y_o(post_fwd));

    assign tbl_addr[k] = mode_i ? pre_inv : in_b;
    assign sub_word[k*BYTE_W +: BYTE_W] = mode_i ? tbl_data[k] : post_fwd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      data_o      <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) data_o <= sub_word;
    end
  end

  always_comb begin
    if (!rst_ni) AST_RESET_IDLE: assert (!out_valid_o); // R1
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R2
  AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(data_o)); // R7
  AST_ZERO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !mode_i && data_i == '0) |=> data_o == {LANES{FWD_C}}); // R8

endmodule

// File: tb/aes_dual_sbox_tb_top.sv
module aes_dual_sbox_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        out_valid_o;
  logic [31:0] data_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  aes_dual_sbox dut_i (
    .clk_i, .rst_ni, .in_valid_i, .mode_i, .data_i, .out_valid_o, .data_o
  );

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h11B << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_inv(logic [7:0] a);
    for (int b = 1; b < 256; b++) if (ref_mul(a, 8'(b)) == 8'h01) return 8'(b);
    return 8'h00;
  endfunction

  function automatic logic [7:0] ref_fwd(logic [7:0] x);
    logic [7:0] a = ref_inv(x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++)
      y[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
    return y;
  endfunction

  function automatic logic [7:0] ref_bwd(logic [7:0] x);
    logic [7:0] a;
    for (int i = 0; i < 8; i++)
      a[i] = x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8] ^ ((8'h05 >> i) & 1'b1);
    return ref_inv(a);
  endfunction

  function automatic logic [31:0] ref_word(logic m, logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = m ? ref_bwd(w[k*8 +: 8]) : ref_fwd(w[k*8 +: 8]);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive at negedge; result is sampled at the following negedge
  task automatic xfer(logic m, logic [31:0] w);
    in_valid_i = 1'b1; mode_i = m; data_i = w;
    @(negedge clk_i);
  endtask

  initial begin
    logic [31:0] prev_w;
    logic        prev_m;
    logic [31:0] held;
    @(negedge clk_i);
    check("R1", 32'(out_valid_o), 32'd0);
    @(negedge clk_i);
    check("R1", 32'(out_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2", 32'(out_valid_o), 32'd0);

    xfer(1'b0, 32'h5300_5300);
    check("R2", 32'(out_valid_o), 32'd1);
    check("R8", data_o, 32'hED63_ED63);
    xfer(1'b1, 32'h63ED_63ED);
    check("R8", data_o, 32'h0053_0053);
    check("R5", data_o, ref_word(1'b1, 32'h63ED_63ED));

    // R9 alternating directions back to back
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w = {8'(i*37), 8'(i*11+5), 8'(i*3+200), 8'(i*91)};
      xfer(1'(i & 1), w);
      check("R9", data_o, ref_word(1'(i & 1), w));
    end

    // R3 / R4 exhaustive sweeps, every byte value reaches every lane, streamed
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 257; x++) begin
        logic [7:0] b = 8'(x);
        logic [31:0] w = {b, b ^ 8'h5A, ~b, b + 8'd77};
        if (x > 0) begin
          check(m ? "R4" : "R3", data_o, ref_word(1'(m), prev_w));
          check("R2", 32'(out_valid_o), 32'd1);
        end
        if (x < 256) begin
          prev_w = w;
          in_valid_i = 1'b1; mode_i = 1'(m); data_i = w;
        end else in_valid_i = 1'b0;
        @(negedge clk_i);
      end
    end

    // R7 idle: inputs change, output holds
    held = data_o;
    check("R2", 32'(out_valid_o), 32'd0);
    in_valid_i = 1'b0; mode_i = 1'b0; data_i = 32'h1234_5678;
    @(negedge clk_i);
    check("R7", data_o, held);
    mode_i = 1'b1; data_i = 32'hFFFF_0000;
    @(negedge clk_i);
    check("R7", data_o, held);
    check("R2", 32'(out_valid_o), 32'd0);

    // R5 single lane varies, others fixed
    xfer(1'b0, 32'h0000_00AB);
    check("R5", data_o, {8'h63, 8'h63, 8'h63, ref_fwd(8'hAB)});
    prev_m = 1'b1;
    xfer(prev_m, 32'hC100_0000);
    check("R5", data_o, {ref_bwd(8'hC1), ref_bwd(8'h00), ref_bwd(8'h00), ref_bwd(8'h00)});
    in_valid_i = 1'b0;
    @(negedge clk_i);

    // R1 reset mid-stream
    in_valid_i = 1'b1;
    #1 rst_ni = 1'b0;
    #1 check("R1", 32'(out_valid_o), 32'd0);
    @(negedge clk_i);
    check("R1", 32'(out_valid_o), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule